// File: doc/BRIEF.md
# Two-Bit Ripple Counter from JK Flip-Flops

This block is a two-bit up counter made of two JK flip-flop instances rather than a single adder register. The low stage has both control inputs tied high, so it toggles on every rising edge of the system clock. The high stage takes its clock from the low stage's complement output, so the count ripples from one stage to the next. The block steps through 0, 1, 2, 3 and then wraps back to 0.

Each flip-flop has one asynchronous active-high reset. The reset and the clocked update sit in the same process, and the state moves only through non-blocking updates. The block brings out both count bits and their complements. It suits small dividers and local sequencing where a ripple between the two stages is acceptable.

Top module: `jkrip_counter`

## Requirements
- R1: While `rst` is 1, `cnt` is 2'b00 and `cnt_n` is 2'b11. The clear takes effect without waiting for a clock edge.
- R2: Outside reset, `cnt[0]` inverts on every rising edge of `clk`.
- R3: `cnt[1]` changes only when `cnt[0]` falls from 1 to 0, and it inverts at each such fall.
- R4: Starting from reset, successive rising clock edges produce the count values 1, 2, 3, 0, 1, 2, 3, 0, 1 on `cnt`, read as an unsigned number with `cnt[1]` as the MSB.
- R5: `cnt_n` is always the bitwise inverse of `cnt`.
- R6: While reset is held across rising edges of `clk`, the count stays at 0.
- R7: The first rising edge of `clk` after reset is released gives a count of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; its rising edge toggles the low stage |
| rst | input | 1 | Asynchronous active-high clear for both stages |
| cnt | output | 2 | Count value; bit 0 is the low stage, bit 1 the high stage |
| cnt_n | output | 2 | Bitwise complement of `cnt` |

## Verification
The assertions sample on the rising edge of `clk` and assume that the ripple into the high stage has settled within the same time step. They also assume that `rst` changes away from clock edges, so that no clock edge coincides with a reset release. The stimulus changes `rst` only at falling edges of `clk`, or a few nanoseconds after one, and it reads the outputs at falling edges, half a period after the edge that moved them.

// File: rtl/jkrip_pkg.sv
package jkrip_pkg;

  localparam int unsigned STAGES = 2;

  typedef enum logic [1:0] {
    JK_HOLD   = 2'b00,
    JK_CLEAR  = 2'b01,
    JK_SET    = 2'b10,
    JK_TOGGLE = 2'b11
  } jk_mode_e;

  function automatic logic jk_next(input logic q, input logic j, input logic k);
    jk_mode_e mode;
    mode = jk_mode_e'({j, k});
    case (mode)
      JK_HOLD:   return q;
      JK_CLEAR:  return 1'b0;
      JK_SET:    return 1'b1;
      default:   return ~q;
    endcase
  endfunction

endpackage

// File: rtl/jkrip_flop.sv
module jkrip_flop
  import jkrip_pkg::*;
(
  input  logic ck,
  input  logic rst,
  input  logic j,
  input  logic k,
  output logic q,
  output logic qn
);

  logic state;

  always_ff @(posedge ck or posedge rst) begin
    if (rst) begin
      state <= 1'b0;
    end else begin
      state <= jk_next(state, j, k);
    end
  end

  assign q  = state;
  assign qn = ~state;

endmodule

// File: rtl/jkrip_counter.sv
module jkrip_counter
  import jkrip_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  output logic [1:0] cnt,
  output logic [1:0] cnt_n
);

  logic lo_q, lo_qn;
  logic hi_q, hi_qn;
  logic hi_clk;
  logic hi_jk;

  assign hi_clk = lo_qn;
  assign hi_jk  = lo_qn;

  jkrip_flop u_lo (
    .ck  (clk),
    .rst (rst),
    .j   (1'b1),
    .k   (1'b1),
    .q   (lo_q),
    .qn  (lo_qn)
  );

  jkrip_flop u_hi (
    .ck  (hi_clk),
    .rst (rst),
    .j   (hi_jk),
    .k   (hi_jk),
    .q   (hi_q),
    .qn  (hi_qn)
  );

  assign cnt   = {hi_q, lo_q};
  assign cnt_n = {hi_qn, lo_qn};

endmodule

// File: rtl/jkrip_counter_chk.sv
module jkrip_counter_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] cnt,
  input logic [1:0] cnt_n
);

  logic [1:0] prev_cnt;
  logic       armed;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      prev_cnt <= 2'b00;
      armed    <= 1'b0;
    end else begin
      prev_cnt <= cnt;
      armed    <= 1'b1;
    end
  end

  always @(negedge clk) begin
    if (rst) begin
      p_clear_in_reset_r1: assert (cnt == 2'b00 && cnt_n == 2'b11)
        else $error("reset did not clear the counter");
    end
  end

  p_lo_toggles_r2: assert property (@(posedge clk) disable iff (rst)
    armed |-> cnt[0] != prev_cnt[0]);

  p_hi_moves_on_lo_fall_r3: assert property (@(posedge clk) disable iff (rst)
    (armed && cnt[1] != prev_cnt[1]) |-> (prev_cnt[0] == 1'b1 && cnt[0] == 1'b0));

  p_step_by_one_r4: assert property (@(posedge clk) disable iff (rst)
    armed |-> cnt == prev_cnt + 2'd1);

  p_complement_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_n == ~cnt);

endmodule

bind jkrip_counter jkrip_counter_chk u_chk (
  .clk   (clk),
  .rst   (rst),
  .cnt   (cnt),
  .cnt_n (cnt_n)
);

// File: tb/tb_jkrip_counter.sv
`timescale 1ns/1ps
module tb_jkrip_counter;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cnt;
  logic [1:0] cnt_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  localparam int NSTEP = 9;
  localparam logic [1:0] EXP_SEQ [NSTEP] = '{2'd1, 2'd2, 2'd3, 2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1};

  jkrip_counter dut (
    .clk   (clk),
    .rst   (rst),
    .cnt   (cnt),
    .cnt_n (cnt_n)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [1:0] got, input logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [1:0] prev;
    // R1 / R6: reset held over two rising edges
    @(negedge clk);
    check("R1 cnt", cnt, 2'b00);
    check("R1 cnt_n", cnt_n, 2'b11);
    @(negedge clk);
    check("R6 cnt", cnt, 2'b00);
    rst = 1'b0;

    // R4 / R2 / R3 / R5 / R7: table walk over two wraps
    prev = 2'b00;
    for (int i = 0; i < NSTEP; i++) begin
      @(negedge clk);
      if (i == 0) check("R7 first", cnt, 2'd1);
      check("R4 seq", cnt, EXP_SEQ[i]);
      check("R5 comp", cnt_n, ~EXP_SEQ[i]);
      check("R2 lsb", {1'b0, cnt[0]}, {1'b0, ~prev[0]});
      if (prev[0] == 1'b1) check("R3 msb flip", {1'b0, cnt[1]}, {1'b0, ~prev[1]});
      else                 check("R3 msb hold", {1'b0, cnt[1]}, {1'b0, prev[1]});
      prev = cnt;
    end

    // R1: asynchronous clear mid-count, away from the edge
    @(negedge clk);
    check("R4 pre", cnt, 2'd2);
    #2 rst = 1'b1;
    #1;
    check("R1 async cnt", cnt, 2'b00);
    check("R1 async cnt_n", cnt_n, 2'b11);
    @(negedge clk);
    check("R6 held", cnt, 2'b00);
    @(negedge clk);
    check("R6 held2", cnt, 2'b00);

    // R7: release again and count up to 3, then clear from 3
    rst = 1'b0;
    @(negedge clk);
    check("R7 restart", cnt, 2'd1);
    @(negedge clk);
    @(negedge clk);
    check("R4 three", cnt, 2'd3);
    check("R5 three", cnt_n, 2'd0);
    #3 rst = 1'b1;
    #1;
    check("R1 from three", cnt, 2'b00);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R7 third", cnt, 2'd1);
    finish_run();
  end

endmodule